// File: doc/BRIEF.md
# Indexed Host Register Front End for a Byte FIFO Pair

This block sits between a host bus with a 3-bit byte address and a pair of byte FIFOs: one carries bytes outbound from the host to a local board, the other carries bytes inbound. The host moves data through one data offset. It reads a live status byte and can raise an interrupt. It reaches the rest of the control state through one shared offset, which holds a selection pointer.

A write to the shared offset does not change any register. It loads an index and arms the offset. The next single access to that offset, read or write, reaches the chosen internal register. The offset then returns to the status and pointer role. The internal registers are:

- a command register (self-clearing reset and status-view swap);
- an interrupt mask;
- a byte-match pattern;
- a threshold for the almost-full and almost-empty flags;
- a one-byte mailbox in each direction.

The FIFO storage and any line-error detection live outside the block. The block sees the FIFO fill levels, the inbound head byte and an error level, and drives push, pop and clear strobes. The board side writes the inbound mailbox, takes the outbound mailbox and enables host interrupts through single-cycle strobes.

Top module: `ptr_fifo_regs`

## Requirements
- R1: After rst_n is released: the pointer is not armed, the mask, command view, byte pattern, threshold and both mailboxes hold zero, the reset-indication flag is set and the global interrupt enable is clear, so h_irq is 0.
- R2: A write at offset 2 while not armed arms the pointer. The next read or write at offset 2, and only that one, reaches the selected register. The access after it sees status (read) or the pointer (write) again. Accesses at other offsets neither use nor cancel an armed pointer.
- R3: Index codes are 1 command, 2 mask, 3 byte pattern, 4 outbound mailbox, 5 threshold, 6 inbound mailbox. Any other written byte selects nothing: the following write changes no state and the following read returns 0. Mask bit 7 is not stored and reads 0. The inbound mailbox ignores host writes.
- R4: Status bits: bit 7 reset flag; bit 6 outbound level equals DEPTH; bit 5 inbound level is 0; bit 4 outbound level plus threshold is at least DEPTH; bit 3 inbound level is at most the threshold; bit 2 inbound mailbox full; bit 1 inbound level nonzero and head byte equals the pattern; bit 0 ib_perr high. Bits 6 to 0 follow their conditions in the same cycle.
- R5: A status read at offset 2 while not armed clears the reset flag on the following edge.
- R6: h_irq = global enable AND (reset flag OR any of status bits 6..0 ANDed with the mask). A bd_irq_en strobe sets the enable.
- R7: A command write with bit 7 set pulses fifo_clr in that cycle, sets the reset flag and clears both mailboxes, the inbound-full flag and the view swap. Otherwise bit 6 of the command sets the swap: while it is set, status reads return bd_status. A command read returns the swap in bit 6.
- R8: A host write to index 4 is presented on bd_mb_rdata. A bd_mb_rd strobe clears it to zero, and the host reads that zero back through index 4. A host write in the same cycle wins.
- R9: A bd_mb_wr strobe stores bd_mb_wdata and sets status bit 2. A host read through index 6 returns the byte and clears bit 2. A board write in the same cycle wins.
- R10: A write at offset 0 pulses ob_push with ob_data equal to h_wdata, unless the outbound level equals DEPTH. A read at offset 0 pulses ib_pop and returns ib_head, unless the inbound level is 0, in which case it returns 0 with no pop.
- R11: A write at offset 7 pulses board_rst, sets the reset flag and clears the global enable. Reads at offsets 1, 3 to 7 return 0 and writes at offsets 1, 3 to 6 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_addr | input | 3 | Host byte offset |
| h_wr | input | 1 | Host write strobe, one cycle per access |
| h_rd | input | 1 | Host read strobe, one cycle per access |
| h_wdata | input | 8 | Host write byte |
| h_rdata | output | 8 | Host read byte, valid in the cycle of h_rd |
| h_irq | output | 1 | Host interrupt request, level |
| ob_level | input | LW | Outbound FIFO fill level |
| ob_push | output | 1 | Push strobe to outbound FIFO |
| ob_data | output | 8 | Byte to push |
| ib_level | input | LW | Inbound FIFO fill level |
| ib_head | input | 8 | Byte at the inbound FIFO head |
| ib_pop | output | 1 | Pop strobe to inbound FIFO |
| ib_perr | input | 1 | Line error condition from outside |
| fifo_clr | output | 1 | FIFO clear strobe from the command register |
| board_rst | output | 1 | Board reset strobe |
| bd_status | input | 8 | Board-side status shown while the view is swapped |
| bd_irq_en | input | 1 | Board strobe that enables host interrupts |
| bd_mb_wr | input | 1 | Board writes the inbound mailbox |
| bd_mb_wdata | input | 8 | Board mailbox byte |
| bd_mb_rd | input | 1 | Board takes the outbound mailbox |
| bd_mb_rdata | output | 8 | Outbound mailbox contents |

## Verification
The index mechanism is tried with pointer writes followed by a read, by a write, and by an unrelated offset access, to separate one-shot routing from a sticky or cancelled selection. Valid, zero and out-of-range index bytes show that reserved codes reach nothing. Fill levels are driven at and one step on either side of DEPTH, zero and the threshold, so off-by-one compares show up in status. The interrupt is watched while the reset flag, the mask and the global enable change one at a time, which isolates the unmaskable flag from the masked bits.

// File: rtl/pfr_pkg.sv
// Shared offsets, index codes and status bit positions for the indexed FIFO
// register front end. Assumes a 3-bit host byte address.
package pfr_pkg;

    localparam logic [2:0] OFS_DATA = 3'd0;
    localparam logic [2:0] OFS_CTRL = 3'd2;
    localparam logic [2:0] OFS_BRST = 3'd7;

    typedef enum logic [2:0] {
        IX_NONE = 3'd0,
        IX_CMD  = 3'd1,
        IX_MASK = 3'd2,
        IX_PAT  = 3'd3,
        IX_OMB  = 3'd4,
        IX_THR  = 3'd5,
        IX_IMB  = 3'd6,
        IX_RSV  = 3'd7
    } ix_e;

    localparam int SB_RST  = 7;
    localparam int SB_OFUL = 6;
    localparam int SB_IEMP = 5;
    localparam int SB_OAF  = 4;
    localparam int SB_IAE  = 3;
    localparam int SB_IMB  = 2;
    localparam int SB_PAT  = 1;
    localparam int SB_PERR = 0;

    localparam int CB_CLR  = 7;
    localparam int CB_SWAP = 6;

endpackage

// File: rtl/pfr_index.sv
// One-shot index pointer. A write while disarmed loads an index and arms;
// the next access of either kind disarms. Assumes acc_wr and acc_rd are
// already qualified by the control offset and are never both high.
module pfr_index
    import pfr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_wr,
    input  logic       acc_rd,
    input  logic [7:0] wdata,
    output logic       armed,
    output ix_e        sel
);

    ix_e sel_dec;

    // Map the written byte to an index; out-of-range bytes select nothing.
    always_comb begin
        if (wdata >= 8'd1 && wdata <= 8'd6)
            sel_dec = ix_e'(wdata[2:0]);
        else
            sel_dec = IX_NONE;
    end

    // Arm on a pointer write, disarm after exactly one routed access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            sel   <= IX_NONE;
        end else if (armed && (acc_wr || acc_rd)) begin
            armed <= 1'b0;
        end else if (!armed && acc_wr) begin
            armed <= 1'b1;
            sel   <= sel_dec;
        end
    end

endmodule

// File: rtl/pfr_mailbox.sv
// Pair of one-byte mailboxes. The outbound box is written by the host and
// zeroed when the board takes it; the inbound box is written by the board and
// flags full until the host reads it. clr has top priority, then the writer.
module pfr_mailbox #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         host_wr,
    input  logic         host_rd,
    input  logic [W-1:0] host_wdata,
    input  logic         bd_wr,
    input  logic         bd_rd,
    input  logic [W-1:0] bd_wdata,
    output logic [W-1:0] omb_q,
    output logic [W-1:0] imb_q,
    output logic         imb_full
);

    // Outbound mailbox: host fills, board empties to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            omb_q <= '0;
        else if (host_wr)
            omb_q <= host_wdata;
        else if (bd_rd)
            omb_q <= '0;
    end

    // Inbound mailbox: board fills and flags, host read drops the flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            imb_q    <= '0;
            imb_full <= 1'b0;
        end else if (bd_wr) begin
            imb_q    <= bd_wdata;
            imb_full <= 1'b1;
        end else if (host_rd) begin
            imb_full <= 1'b0;
        end
    end

endmodule

// File: rtl/pfr_status.sv
// Assembles the live status byte from FIFO levels and flags, and derives the
// host interrupt. Purely combinational; assumes levels never exceed DEPTH.
module pfr_status
    import pfr_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic [LW-1:0] ob_level,
    input  logic [LW-1:0] ib_level,
    input  logic [7:0]    ib_head,
    input  logic          ib_perr,
    input  logic [7:0]    thr,
    input  logic [7:0]    pat,
    input  logic          imb_full,
    input  logic          rst_flag,
    input  logic [6:0]    mask,
    input  logic          gen,
    output logic [7:0]    status,
    output logic          irq
);

    localparam int CW = ((LW > 8) ? LW : 8) + 1;

    logic [CW-1:0] ob_w, ib_w, thr_w;

    // Widen operands so the threshold sum cannot wrap.
    always_comb begin
        ob_w  = CW'(ob_level);
        ib_w  = CW'(ib_level);
        thr_w = CW'(thr);
    end

    // Status bits, each tracking its condition in the current cycle.
    always_comb begin
        status          = '0;
        status[SB_RST]  = rst_flag;
        status[SB_OFUL] = (ob_level == LW'(DEPTH));
        status[SB_IEMP] = (ib_level == '0);
        status[SB_OAF]  = ((ob_w + thr_w) >= CW'(DEPTH));
        status[SB_IAE]  = (ib_w <= thr_w);
        status[SB_IMB]  = imb_full;
        status[SB_PAT]  = (ib_level != '0) && (ib_head == pat);
        status[SB_PERR] = ib_perr;
    end

    // Reset flag bypasses the mask; everything is gated by the global enable.
    always_comb irq = gen && (rst_flag || (|(status[6:0] & mask)));

endmodule

// File: rtl/ptr_fifo_regs.sv
// Host register front end for a byte FIFO pair with mailboxes. Decodes the
// host offsets, holds mask, pattern, threshold, view swap, reset flag and
// global enable, and muxes read data. Assumes one-cycle h_wr/h_rd strobes that
// are never both high.
module ptr_fifo_regs
    import pfr_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    h_addr,
    input  logic          h_wr,
    input  logic          h_rd,
    input  logic [7:0]    h_wdata,
    output logic [7:0]    h_rdata,
    output logic          h_irq,
    input  logic [LW-1:0] ob_level,
    output logic          ob_push,
    output logic [7:0]    ob_data,
    input  logic [LW-1:0] ib_level,
    input  logic [7:0]    ib_head,
    output logic          ib_pop,
    input  logic          ib_perr,
    output logic          fifo_clr,
    output logic          board_rst,
    input  logic [7:0]    bd_status,
    input  logic          bd_irq_en,
    input  logic          bd_mb_wr,
    input  logic [7:0]    bd_mb_wdata,
    input  logic          bd_mb_rd,
    output logic [7:0]    bd_mb_rdata
);

    logic       ctl_wr, ctl_rd, armed, reg_wr, reg_rd, st_rd;
    logic       omb_wr, imb_rd, cmd_wr;
    ix_e        sel;
    logic [6:0] mask_q;
    logic [7:0] pat_q, thr_q, omb_q, imb_q, status;
    logic       swap_q, rst_flag, gen, imb_full;

    // Offset decode for the shared control address and the routed access.
    always_comb begin
        ctl_wr    = h_wr && (h_addr == OFS_CTRL);
        ctl_rd    = h_rd && (h_addr == OFS_CTRL);
        reg_wr    = ctl_wr && armed;
        reg_rd    = ctl_rd && armed;
        st_rd     = ctl_rd && !armed;
        cmd_wr    = reg_wr && (sel == IX_CMD);
        omb_wr    = reg_wr && (sel == IX_OMB);
        imb_rd    = reg_rd && (sel == IX_IMB);
        fifo_clr  = cmd_wr && h_wdata[CB_CLR];
        board_rst = h_wr && (h_addr == OFS_BRST);
        ob_push   = h_wr && (h_addr == OFS_DATA) && (ob_level != LW'(DEPTH));
        ob_data   = h_wdata;
        ib_pop    = h_rd && (h_addr == OFS_DATA) && (ib_level != '0);
    end

    pfr_index u_index (
        .clk    (clk),
        .rst_n  (rst_n),
        .acc_wr (ctl_wr),
        .acc_rd (ctl_rd),
        .wdata  (h_wdata),
        .armed  (armed),
        .sel    (sel)
    );

    pfr_mailbox #(.W(8)) u_mbox (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (fifo_clr),
        .host_wr    (omb_wr),
        .host_rd    (imb_rd),
        .host_wdata (h_wdata),
        .bd_wr      (bd_mb_wr),
        .bd_rd      (bd_mb_rd),
        .bd_wdata   (bd_mb_wdata),
        .omb_q      (omb_q),
        .imb_q      (imb_q),
        .imb_full   (imb_full)
    );

    pfr_status #(.DEPTH(DEPTH), .LW(LW)) u_status (
        .ob_level (ob_level),
        .ib_level (ib_level),
        .ib_head  (ib_head),
        .ib_perr  (ib_perr),
        .thr      (thr_q),
        .pat      (pat_q),
        .imb_full (imb_full),
        .rst_flag (rst_flag),
        .mask     (mask_q),
        .gen      (gen),
        .status   (status),
        .irq      (h_irq)
    );

    // Plain indexed registers: mask, byte pattern and threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            pat_q  <= '0;
            thr_q  <= '0;
        end else if (reg_wr) begin
            case (sel)
                IX_MASK: mask_q <= h_wdata[6:0];
                IX_PAT:  pat_q  <= h_wdata;
                IX_THR:  thr_q  <= h_wdata;
                default: ;
            endcase
        end
    end

    // Status view swap, cleared by the self-clearing reset command.
    always_ff @(posedge clk) begin
        if (!rst_n)
            swap_q <= 1'b0;
        else if (cmd_wr)
            swap_q <= h_wdata[CB_CLR] ? 1'b0 : h_wdata[CB_SWAP];
    end

    // Reset-indication flag: set by any reset, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n || fifo_clr || board_rst)
            rst_flag <= 1'b1;
        else if (st_rd)
            rst_flag <= 1'b0;
    end

    // Global interrupt enable: off after reset until the board turns it on.
    always_ff @(posedge clk) begin
        if (!rst_n || board_rst)
            gen <= 1'b0;
        else if (bd_irq_en)
            gen <= 1'b1;
    end

    // Host read data mux.
    always_comb begin
        h_rdata = '0;
        if (h_addr == OFS_DATA) begin
            if (ib_level != '0) h_rdata = ib_head;
        end else if (h_addr == OFS_CTRL) begin
            if (!armed) begin
                h_rdata = swap_q ? bd_status : status;
            end else begin
                case (sel)
                    IX_CMD:  h_rdata = {1'b0, swap_q, 6'b0};
                    IX_MASK: h_rdata = {1'b0, mask_q};
                    IX_PAT:  h_rdata = pat_q;
                    IX_OMB:  h_rdata = omb_q;
                    IX_THR:  h_rdata = thr_q;
                    IX_IMB:  h_rdata = imb_q;
                    default: h_rdata = '0;
                endcase
            end
        end
    end

    assign bd_mb_rdata = omb_q;

endmodule

// File: rtl/pfr_checker.sv
// Temporal checks on the indexed FIFO register front end, bound to the top.
module pfr_checker #(
    parameter int DEPTH = 512,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    h_addr,
    input logic          h_wr,
    input logic          h_rd,
    input logic          h_irq,
    input logic          armed,
    input logic          rst_flag,
    input logic          gen,
    input logic          omb_wr,
    input logic          ob_push,
    input logic [LW-1:0] ob_level,
    input logic          ib_pop,
    input logic [LW-1:0] ib_level,
    input logic          fifo_clr,
    input logic          bd_mb_rd,
    input logic [7:0]    bd_mb_rdata
);

    a_r2_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && h_wr && h_addr == 3'd2) |=> armed);

    a_r2_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && h_addr == 3'd2 && (h_wr || h_rd)) |=> !armed);

    a_r5_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && h_rd && !h_wr && h_addr == 3'd2) |=> !rst_flag);

    a_r6_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !gen |-> !h_irq);

    a_r6_unmaskable: assert property (@(posedge clk) disable iff (!rst_n)
        (gen && rst_flag) |-> h_irq);

    a_r7_clear_effects: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> (rst_flag && bd_mb_rdata == 8'd0));

    a_r8_board_take: assert property (@(posedge clk) disable iff (!rst_n)
        (bd_mb_rd && !omb_wr) |=> bd_mb_rdata == 8'd0);

    a_r10_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        ob_push |-> ob_level != LW'(DEPTH));

    a_r10_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        ib_pop |-> ib_level != '0);

    a_r11_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && h_addr == 3'd7) |=> (!h_irq && rst_flag));

endmodule

bind ptr_fifo_regs pfr_checker #(.DEPTH(DEPTH), .LW(LW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .h_addr      (h_addr),
    .h_wr        (h_wr),
    .h_rd        (h_rd),
    .h_irq       (h_irq),
    .armed       (armed),
    .rst_flag    (rst_flag),
    .gen         (gen),
    .omb_wr      (omb_wr),
    .ob_push     (ob_push),
    .ob_level    (ob_level),
    .ib_pop      (ib_pop),
    .ib_level    (ib_level),
    .fifo_clr    (fifo_clr),
    .bd_mb_rd    (bd_mb_rd),
    .bd_mb_rdata (bd_mb_rdata)
);

// File: tb/ptr_fifo_regs_bench.sv
module ptr_fifo_regs_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 512;
    localparam int LW         = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    h_addr = '0;
    logic          h_wr = 1'b0, h_rd = 1'b0;
    logic [7:0]    h_wdata = '0;
    logic [7:0]    h_rdata;
    logic          h_irq;
    logic [LW-1:0] ob_level = '0;
    logic          ob_push;
    logic [7:0]    ob_data;
    logic [LW-1:0] ib_level = '0;
    logic [7:0]    ib_head = '0;
    logic          ib_pop;
    logic          ib_perr = 1'b0;
    logic          fifo_clr, board_rst;
    logic [7:0]    bd_status = 8'hC3;
    logic          bd_irq_en = 1'b0, bd_mb_wr = 1'b0, bd_mb_rd = 1'b0;
    logic [7:0]    bd_mb_wdata = '0;
    logic [7:0]    bd_mb_rdata;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Behavioural model state
    int m_armed, m_sel, m_mask, m_pat, m_thr, m_swap, m_omb, m_imb, m_ifull, m_rstf, m_gen;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptr_fifo_regs #(.DEPTH(DEPTH)) u_ptr_fifo_regs (
        .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .h_irq(h_irq),
        .ob_level(ob_level), .ob_push(ob_push), .ob_data(ob_data),
        .ib_level(ib_level), .ib_head(ib_head), .ib_pop(ib_pop), .ib_perr(ib_perr),
        .fifo_clr(fifo_clr), .board_rst(board_rst), .bd_status(bd_status),
        .bd_irq_en(bd_irq_en), .bd_mb_wr(bd_mb_wr), .bd_mb_wdata(bd_mb_wdata),
        .bd_mb_rd(bd_mb_rd), .bd_mb_rdata(bd_mb_rdata));

    function automatic void chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=0x%0h exp=0x%0h at %0t", req, act, exp, $time);
        end
    endfunction

    function automatic void model_reset();
        m_armed = 0; m_sel = 0; m_mask = 0; m_pat = 0; m_thr = 0; m_swap = 0;
        m_omb = 0; m_imb = 0; m_ifull = 0; m_rstf = 1; m_gen = 0;
    endfunction

    function automatic int exp_status();
        int s = 0;
        int ob = int'(ob_level);
        int ib = int'(ib_level);
        if (m_rstf != 0)                         s |= 8'h80;
        if (ob == DEPTH)                         s |= 8'h40;
        if (ib == 0)                             s |= 8'h20;
        if (ob + m_thr >= DEPTH)                 s |= 8'h10;
        if (ib <= m_thr)                         s |= 8'h08;
        if (m_ifull != 0)                        s |= 8'h04;
        if (ib != 0 && int'(ib_head) == m_pat)   s |= 8'h02;
        if (ib_perr)                             s |= 8'h01;
        return s;
    endfunction

    function automatic int exp_read();
        if (h_addr == 3'd0) return (ib_level != 0) ? int'(ib_head) : 0;
        if (h_addr != 3'd2) return 0;
        if (m_armed == 0)   return (m_swap != 0) ? int'(bd_status) : exp_status();
        case (m_sel)
            1: return m_swap != 0 ? 8'h40 : 0;
            2: return m_mask;
            3: return m_pat;
            4: return m_omb;
            5: return m_thr;
            6: return m_imb;
            default: return 0;
        endcase
    endfunction

    // Compare all outputs against the model, then advance the model one edge.
    task automatic cyc(input string req);
        int e_irq, e_push, e_pop, e_clr, e_brst, old_armed;
        #1;
        e_irq  = (m_gen != 0 && (m_rstf != 0 || (exp_status() & m_mask & 8'h7F) != 0)) ? 1 : 0;
        e_push = (h_wr && h_addr == 3'd0 && int'(ob_level) != DEPTH) ? 1 : 0;
        e_pop  = (h_rd && h_addr == 3'd0 && ib_level != 0) ? 1 : 0;
        e_clr  = (h_wr && h_addr == 3'd2 && m_armed != 0 && m_sel == 1 && h_wdata[7]) ? 1 : 0;
        e_brst = (h_wr && h_addr == 3'd7) ? 1 : 0;
        chk(int'(h_irq) == e_irq, "R6 irq", int'(h_irq), e_irq);
        chk(int'(bd_mb_rdata) == m_omb, "R8 outbound mailbox", int'(bd_mb_rdata), m_omb);
        chk(int'(ob_push) == e_push, "R10 push", int'(ob_push), e_push);
        if (e_push != 0) chk(ob_data == h_wdata, "R10 push data", int'(ob_data), int'(h_wdata));
        chk(int'(ib_pop) == e_pop, "R10 pop", int'(ib_pop), e_pop);
        chk(int'(fifo_clr) == e_clr, "R7 fifo_clr", int'(fifo_clr), e_clr);
        chk(int'(board_rst) == e_brst, "R11 board_rst", int'(board_rst), e_brst);
        if (h_rd) chk(int'(h_rdata) == exp_read(), req, int'(h_rdata), exp_read());
        @(posedge clk);
        old_armed = m_armed;
        if (h_wr && h_addr == 3'd2) begin
            if (old_armed == 0) begin
                m_armed = 1;
                m_sel = (h_wdata >= 1 && h_wdata <= 6) ? int'(h_wdata) : 0;
            end else begin
                m_armed = 0;
                case (m_sel)
                    1: if (h_wdata[7]) begin
                           m_rstf = 1; m_swap = 0; m_omb = 0; m_imb = 0; m_ifull = 0;
                       end else m_swap = h_wdata[6];
                    2: m_mask = int'(h_wdata) & 8'h7F;
                    3: m_pat = int'(h_wdata);
                    4: m_omb = int'(h_wdata);
                    5: m_thr = int'(h_wdata);
                    default: ;
                endcase
            end
        end
        if (h_rd && h_addr == 3'd2) begin
            if (old_armed != 0) begin
                m_armed = 0;
                if (m_sel == 6) m_ifull = 0;
            end else m_rstf = 0;
        end
        if (h_wr && h_addr == 3'd7) begin m_rstf = 1; m_gen = 0; end
        else if (bd_irq_en) m_gen = 1;
        if (bd_mb_wr) begin m_imb = int'(bd_mb_wdata); m_ifull = 1; end
        if (bd_mb_rd && !(h_wr && h_addr == 3'd2 && old_armed != 0 && m_sel == 4)) m_omb = 0;
    endtask

    task automatic clr_in();
        h_wr = 0; h_rd = 0; bd_irq_en = 0; bd_mb_wr = 0; bd_mb_rd = 0;
    endtask

    task automatic hw(input logic [2:0] a, input logic [7:0] d, input string req);
        @(negedge clk); clr_in(); h_addr = a; h_wdata = d; h_wr = 1; cyc(req);
    endtask

    task automatic hr(input logic [2:0] a, input string req);
        @(negedge clk); clr_in(); h_addr = a; h_rd = 1; cyc(req);
    endtask

    task automatic idle(input string req);
        @(negedge clk); clr_in(); cyc(req);
    endtask

    task automatic lv(input int ob, input int ib, input logic [7:0] hd, input logic pe);
        @(negedge clk); clr_in();
        ob_level = LW'(ob); ib_level = LW'(ib); ib_head = hd; ib_perr = pe;
        cyc("R4 levels");
    endtask

    task automatic bd(input logic en, input logic wr, input logic rd, input logic [7:0] d);
        @(negedge clk); clr_in();
        bd_irq_en = en; bd_mb_wr = wr; bd_mb_rd = rd; bd_mb_wdata = d;
        cyc("R6 board strobe");
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog act=hung exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R1: reset state
        idle("R1 reset idle");
        hr(3'd2, "R1 reset status");
        // R5: flag cleared by that read
        hr(3'd2, "R5 status after read");
        // R6: enable, then mask the inbound-empty bit
        bd(1, 0, 0, 8'h00);
        hw(3'd2, 8'd2, "R2 arm mask");
        hw(3'd2, 8'h20, "R3 write mask");
        idle("R6 masked empty raises irq");
        // R2: one routed access, then back to status
        hw(3'd2, 8'd2, "R2 arm");
        hr(3'd2, "R3 mask readback");
        hr(3'd2, "R2 back to status");
        // R2: other offsets do not cancel an armed pointer
        hw(3'd2, 8'd3, "R2 arm pattern");
        hr(3'd7, "R11 read offset 7");
        hw(3'd2, 8'h5A, "R2 pattern routed after offset 7 read");
        hw(3'd2, 8'd2, "R2 arm");
        hw(3'd2, 8'hFF, "R3 mask bit7 dropped");
        hw(3'd2, 8'd2, "R2 arm");
        hr(3'd2, "R3 mask reads 0x7F");
        hw(3'd2, 8'd2, "R2 arm");
        hw(3'd2, 8'h00, "R3 mask off");
        // R4: threshold compares at boundaries
        hw(3'd2, 8'd5, "R2 arm thr");
        hw(3'd2, 8'h10, "R3 thr write");
        lv(495, 16, 8'h11, 0); hr(3'd2, "R4 status 495/16");
        lv(496, 17, 8'h11, 0); hr(3'd2, "R4 status 496/17");
        lv(512, 17, 8'h5A, 1); hr(3'd2, "R4 status full/pattern/perr");
        lv(511, 0, 8'h5A, 0);  hr(3'd2, "R4 status empty no pattern");
        // R10: data port
        lv(512, 3, 8'h5A, 0);
        hw(3'd0, 8'hA5, "R10 no push when full");
        lv(3, 3, 8'h5A, 0);
        hw(3'd0, 8'hA5, "R10 push");
        hr(3'd0, "R10 pop returns head");
        lv(3, 0, 8'h5A, 0);
        hr(3'd0, "R10 empty read zero");
        // R8: outbound mailbox
        hw(3'd2, 8'd4, "R2 arm omb");
        hw(3'd2, 8'h3C, "R8 omb write");
        hw(3'd2, 8'd4, "R2 arm omb");
        hr(3'd2, "R8 omb readback");
        bd(0, 0, 1, 8'h00);
        hw(3'd2, 8'd4, "R2 arm omb");
        hr(3'd2, "R8 omb taken reads zero");
        // R9: inbound mailbox with irq
        hw(3'd2, 8'd2, "R2 arm mask");
        hw(3'd2, 8'h04, "R9 mask mailbox");
        bd(0, 1, 0, 8'h77);
        hr(3'd2, "R9 status mailbox full");
        hw(3'd2, 8'd6, "R2 arm imb");
        hw(3'd2, 8'h99, "R3 imb write ignored");
        hw(3'd2, 8'd6, "R2 arm imb");
        hr(3'd2, "R9 imb read");
        hr(3'd2, "R9 status flag cleared");
        // R3: reserved indexes
        hw(3'd2, 8'd7, "R3 arm reserved 7");
        hw(3'd2, 8'hFF, "R3 reserved write");
        hw(3'd2, 8'h11, "R3 arm out of range");
        hr(3'd2, "R3 reserved read zero");
        hw(3'd2, 8'd0, "R3 arm zero");
        hr(3'd2, "R3 zero index read");
        hw(3'd2, 8'd5, "R2 arm thr");
        hr(3'd2, "R3 thr unchanged");
        // R11: unused offsets
        hw(3'd1, 8'hEE, "R11 offset 1 write");
        hw(3'd3, 8'hEE, "R11 offset 3 write");
        hr(3'd1, "R11 offset 1 read");
        hr(3'd5, "R11 offset 5 read");
        hr(3'd2, "R11 status unchanged");
        // R7: view swap and chip reset
        hw(3'd2, 8'd1, "R2 arm cmd");
        hw(3'd2, 8'h40, "R7 swap on");
        hr(3'd2, "R7 swapped status");
        hw(3'd2, 8'd1, "R2 arm cmd");
        hr(3'd2, "R7 cmd readback");
        hw(3'd2, 8'd1, "R2 arm cmd");
        hw(3'd2, 8'h00, "R7 swap off");
        hr(3'd2, "R7 normal status");
        hw(3'd2, 8'd4, "R2 arm omb");
        hw(3'd2, 8'h5C, "R8 omb load");
        bd(0, 1, 0, 8'h66);
        hw(3'd2, 8'd1, "R2 arm cmd");
        hw(3'd2, 8'h80, "R7 chip reset");
        idle("R7 after chip reset irq unmasked");
        hw(3'd2, 8'd6, "R2 arm imb");
        hr(3'd2, "R7 imb cleared");
        hr(3'd2, "R7 status flag set");
        // R11: board reset
        hw(3'd7, 8'h00, "R11 board reset");
        idle("R11 irq off");
        bd(1, 0, 0, 8'h00);
        idle("R6 unmaskable flag");
        hr(3'd2, "R5 clear again");
        idle("R6 end");
        done = 1;
        summary();
        $finish;
    end

endmodule